// File: doc/BRIEF.md
# Serial Word Deserializer

This block turns a one-bit serial stream into 32-bit parallel words. A single-cycle sync pulse marks the start of each word. On that clock the block samples a 5-bit width setting, which says how many serial bits make up the word. The data bits are then taken one per enabled clock, most significant bit first. When the final bit arrives, the assembled word is copied into a 32-bit holding register and a one-cycle valid strobe is raised.

Words shorter than 32 bits are left-justified in the holding register, and the unused low-order bits read as zero. Words can follow each other with no idle gap: the sync for the next word may share the clock of the previous word's final bit. A clock enable gates every state change, so the stream can run at any fraction of the clock rate. A sync that arrives in the middle of a word abandons that word and starts counting again.

Top module: `serial_word_deser`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block clears `hold_word` to zero and `word_valid` to 0 by the following cycle.
- R2: Bits enter most significant first. The first bit sampled after sync ends up in `hold_word[31]` of a 32-bit word.
- R3: A clock edge with `clk_en` and `ser_sync` high starts a word. The next W enabled edges each sample one bit from `ser_din`. At the edge that samples bit W, `hold_word` is loaded and `word_valid` is high for exactly the following cycle.
- R4: A word of width W < 32 appears in `hold_word[31:32-W]`, and bits `[31-W:0]` are zero.
- R5: The width setting `word_width` is decoded as follows. Code 0 selects 32 bits, codes 1 to 7 select 8 bits, and codes 8 to 31 select that many bits. The code is taken only on the sync edge, so later changes have no effect on the current word.
- R6: If sync is high on the edge that samples a word's last bit, that word still completes, and the next word's first bit is sampled on the very next enabled edge.
- R7: If sync arrives while two or more bits of a word are still outstanding, that word is discarded with no strobe and no change to `hold_word`. A fresh full-width countdown then begins.
- R8: Edges with `clk_en` low are ignored. No bit is sampled, sync has no effect, and no strobe is raised.
- R9: While no word is in progress, `ser_din` activity without sync produces no strobe and leaves `hold_word` unchanged.
- R10: `hold_word` keeps its value between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en | input | 1 | Clock enable; the block advances only on edges where this is high |
| ser_din | input | 1 | Serial data bit |
| ser_sync | input | 1 | Word-start pulse |
| word_width | input | 5 | Word width code, sampled on the sync edge |
| hold_word | output | 32 | Holding register holding the last complete word, left-justified |
| word_valid | output | 1 | One-cycle strobe that marks a holding-register update |

## Verification
Directed words use a 32-bit pattern with both end bits set, which separates MSB-first order from reversed order. Short words use patterns that would leave nonzero low bits if justification failed. Width codes 0, 3, 8, 20 and 31 distinguish the three decode ranges. Back-to-back words whose sync shares the last bit's clock test the last-bit/sync overlap, and partial words cut short by a new sync show whether an aborted word leaks out. The random phase mixes all widths, gaps with the enable low that carry random sync and data, and width codes that change mid-word. This exposes any counter that runs on disabled edges or reloads its width outside sync.

// File: rtl/deser_pkg.sv
// Package: shared helpers for the serial word deserializer.
// Assumes: callers pass the raw width code and the legal length limits.
package deser_pkg;

    // Map a raw width code to an effective word length in bits.
    function automatic int unsigned deser_eff_len(
        input int unsigned code,
        input int unsigned max_len,
        input int unsigned min_len
    );
        if (code == 0 || code > max_len) return max_len;
        if (code < min_len) return min_len;
        return code;
    endfunction

endpackage

// File: rtl/deser_ctrl.sv
// Module: deser_ctrl
// Counts the bits of the current word down from the length latched at sync.
// Flags every enabled bit slot and the slot that carries the final bit.
// Assumes: sync is honoured only on enabled edges; a sync on a final-bit
// slot lets that word finish and starts the next one.
module deser_ctrl
    import deser_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MIN_W  = 8,
    parameter int SEL_W  = 5,
    parameter int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             sync_in,
    input  logic [SEL_W-1:0] width_sel,
    output logic             shift_en,
    output logic             word_done,
    output logic [CNT_W-1:0] cur_len,
    output logic [CNT_W-1:0] bits_left
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] dec_len;

    // Decode the width code into a bit count.
    assign dec_len = CNT_W'(deser_eff_len(32'(width_sel), DATA_W, MIN_W));

    // Reload on sync, otherwise count down while a word is active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            len_q <= CNT_W'(DATA_W);
        end else if (clk_en) begin
            if (sync_in) begin
                cnt_q <= dec_len;
                len_q <= dec_len;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    // Bit slot strobes for the datapath.
    always_comb begin
        shift_en  = clk_en && (cnt_q != '0);
        word_done = shift_en && (cnt_q == CNT_W'(1));
    end

    assign cur_len   = len_q;
    assign bits_left = cnt_q;

endmodule

// File: rtl/deser_shift.sv
// Module: deser_shift
// Shift register that takes one serial bit per enabled slot, MSB first.
// Exposes the value it will hold after the current slot, so that the final
// bit can be transferred at the same edge.
// Assumes: stale upper bits are discarded downstream by justification.
module deser_shift #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    output logic [DATA_W-1:0] next_word
);

    logic [DATA_W-1:0] sr_q;

    // Next contents with the incoming bit appended at the low end.
    assign next_word = {sr_q[DATA_W-2:0], din};

    // Advance the register on each bit slot.
    always_ff @(posedge clk) begin
        if (!rst_n)        sr_q <= '0;
        else if (shift_en) sr_q <= next_word;
    end

endmodule

// File: rtl/deser_hold.sv
// Module: deser_hold
// Left-justifies a finished word of cur_len bits with a logarithmic shifter,
// which zeroes the vacated low bits, and loads it into the holding register
// with a one-cycle strobe.
// Assumes: len lies between the minimum word width and DATA_W.
module deser_hold #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] word_in,
    input  logic [CNT_W-1:0]  len,
    output logic [DATA_W-1:0] hold_q,
    output logic              valid_q
);

    logic [CNT_W-1:0]  shamt;
    logic [DATA_W-1:0] stage [0:CNT_W];

    // Distance to move the word so that its first bit reaches the MSB.
    assign shamt    = CNT_W'(DATA_W) - len;
    assign stage[0] = word_in;

    // One shifter stage per bit of the shift amount.
    for (genvar s = 0; s < CNT_W; s++) begin : g_stage
        assign stage[s+1] = shamt[s] ? (stage[s] << (2 ** s)) : stage[s];
    end

    // Capture the justified word and pulse the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= load;
            if (load) hold_q <= stage[CNT_W];
        end
    end

endmodule

// File: rtl/serial_word_deser.sv
// Module: serial_word_deser (top)
// Assembles sync-framed serial words of programmable width into a 32-bit
// left-justified holding register with a one-cycle valid strobe.
// Assumes: a single clock domain; the upstream source aligns sync and data
// with clk_en.
module serial_word_deser #(
    parameter int DATA_W = 32,
    parameter int MIN_W  = 8,
    parameter int SEL_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              ser_din,
    input  logic              ser_sync,
    input  logic [SEL_W-1:0]  word_width,
    output logic [DATA_W-1:0] hold_word,
    output logic              word_valid
);

    localparam int CNT_W = $clog2(DATA_W + 1);

    logic              shift_en;
    logic              word_done;
    logic [CNT_W-1:0]  cur_len;
    logic [CNT_W-1:0]  bits_left;
    logic [DATA_W-1:0] next_word;

    deser_ctrl #(
        .DATA_W (DATA_W),
        .MIN_W  (MIN_W),
        .SEL_W  (SEL_W),
        .CNT_W  (CNT_W)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .sync_in   (ser_sync),
        .width_sel (word_width),
        .shift_en  (shift_en),
        .word_done (word_done),
        .cur_len   (cur_len),
        .bits_left (bits_left)
    );

    deser_shift #(
        .DATA_W (DATA_W)
    ) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (shift_en),
        .din       (ser_din),
        .next_word (next_word)
    );

    deser_hold #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (word_done),
        .word_in (next_word),
        .len     (cur_len),
        .hold_q  (hold_word),
        .valid_q (word_valid)
    );

endmodule

// File: rtl/deser_chk.sv
// Module: deser_chk
// Property checker for serial_word_deser, bound to every instance of it.
module deser_chk #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic [DATA_W-1:0] hold_word,
    input logic              word_valid,
    input logic [CNT_W-1:0]  bits_left
);

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (!word_valid && hold_word == '0)); // R1
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) word_valid |=> !word_valid); // R3
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) bits_left <= CNT_W'(DATA_W)); // R5
    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) !clk_en |=> (!word_valid && $stable(bits_left))); // R8
    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n) !word_valid |-> $stable(hold_word)); // R10

endmodule

bind serial_word_deser deser_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .hold_word  (hold_word),
    .word_valid (word_valid),
    .bits_left  (bits_left)
);

// File: tb/test_serial_word_deser.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random words for serial_word_deser.
module test_serial_word_deser;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b0;
    logic        ser_din = 1'b0;
    logic        ser_sync = 1'b0;
    logic [4:0]  word_width = '0;
    logic [31:0] hold_word;
    logic        word_valid;

    int          tests = 0;
    int          fails = 0;
    bit          exp_pending = 1'b0;
    logic [31:0] exp_hold = '0;
    string       cur_tag = "R1";

    always #4 clk = ~clk;

    serial_word_deser i_serial_word_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_en     (clk_en),
        .ser_din    (ser_din),
        .ser_sync   (ser_sync),
        .word_width (word_width),
        .hold_word  (hold_word),
        .word_valid (word_valid)
    );

    // Effective length per R5.
    function automatic int eff(input logic [4:0] c);
        if (c == 5'd0) return 32;
        if (c < 5'd8)  return 8;
        return int'(c);
    endfunction

    // Expected left-justified word per R4.
    function automatic logic [31:0] justify(input logic [31:0] d, input int w);
        logic [31:0] m;
        m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
        return (d & m) << (32 - w);
    endfunction

    task automatic chk();
        tests++;
        if (word_valid !== exp_pending || hold_word !== exp_hold) begin
            fails++;
            $display("FAIL %s: valid=%0b hold=%08h expected valid=%0b hold=%08h",
                     cur_tag, word_valid, hold_word, exp_pending, exp_hold);
        end
        exp_pending = 1'b0;
    endtask

    task automatic cyc(input logic s, input logic d, input logic e, input logic [4:0] w);
        @(negedge clk);
        chk();
        ser_sync = s; ser_din = d; clk_en = e; word_width = w;
    endtask

    // Disabled cycles with random sync, data and width (R8).
    task automatic gaps(input int maxg);
        int n;
        n = (maxg > 0) ? int'($urandom_range(maxg, 0)) : 0;
        for (int g = 0; g < n; g++)
            cyc(1'($urandom), 1'($urandom), 1'b0, 5'($urandom));
    endtask

    task automatic send(input logic [4:0] code, input logic [31:0] data, input bit pre_sync,
                        input bit last_sync, input logic [4:0] next_code, input int maxgap);
        int w;
        w = eff(code);
        if (pre_sync) begin
            gaps(maxgap);
            cyc(1'b1, 1'($urandom), 1'b1, code);
        end
        for (int i = 0; i < w; i++) begin
            gaps(maxgap);
            if (i == w - 1)
                cyc(1'(last_sync), data[w-1-i], 1'b1, last_sync ? next_code : 5'($urandom));
            else
                cyc(1'b0, data[w-1-i], 1'b1, 5'($urandom));
        end
        exp_pending = 1'b1;
        exp_hold = justify(data, w);
    endtask

    // Start a word and feed k of its bits (k at most width-2).
    task automatic partial(input logic [4:0] code, input int k);
        cyc(1'b1, 1'($urandom), 1'b1, code);
        for (int i = 0; i < k; i++) cyc(1'b0, 1'($urandom), 1'b1, 5'($urandom));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'($urandom), 1'b1, 5'($urandom));
    endtask

    initial begin
        bit          prev_last;
        logic [4:0]  code;
        logic [4:0]  ncode;
        void'($urandom(32'd2024));
        // R1: reset state
        repeat (3) @(negedge clk);
        chk();
        rst_n = 1'b1;
        clk_en = 1'b1;
        idle(2);

        cur_tag = "R2";
        send(5'd0, 32'h8000_0001, 1'b1, 1'b0, 5'd0, 0);
        idle(2);
        send(5'd0, 32'hC000_0000, 1'b1, 1'b0, 5'd0, 0);
        idle(1);

        cur_tag = "R4";
        send(5'd8, 32'h0000_00A5, 1'b1, 1'b0, 5'd0, 0);
        idle(1);
        send(5'd20, 32'h000A_BCDE, 1'b1, 1'b0, 5'd0, 0);
        idle(1);
        send(5'd31, 32'h7FFF_FFFF, 1'b1, 1'b0, 5'd0, 0);
        idle(1);

        cur_tag = "R5";
        send(5'd3, 32'h0000_003C, 1'b1, 1'b0, 5'd0, 0);
        idle(1);
        send(5'd1, 32'h0000_00FF, 1'b1, 1'b0, 5'd0, 0);
        idle(1);
        send(5'd0, 32'h1234_5678, 1'b1, 1'b0, 5'd0, 0);
        idle(1);

        cur_tag = "R6";
        send(5'd12, 32'h0000_0ABC, 1'b1, 1'b1, 5'd16, 0);
        send(5'd16, 32'h0000_F00D, 1'b0, 1'b1, 5'd8, 0);
        send(5'd8, 32'h0000_0081, 1'b0, 1'b0, 5'd0, 0);
        idle(2);

        cur_tag = "R7";
        partial(5'd0, 10);
        send(5'd8, 32'h0000_005A, 1'b1, 1'b0, 5'd0, 0);
        idle(1);
        partial(5'd16, 14);
        partial(5'd9, 0);
        send(5'd24, 32'h00C3_3C5A, 1'b1, 1'b0, 5'd0, 0);
        idle(1);

        cur_tag = "R8";
        send(5'd10, 32'h0000_02D1, 1'b1, 1'b0, 5'd0, 3);
        gaps(4);
        idle(1);

        cur_tag = "R9";
        idle(40);
        cur_tag = "R10";
        for (int i = 0; i < 10; i++) cyc(1'b0, 1'($urandom), 1'($urandom), 5'($urandom));

        cur_tag = "R3";
        prev_last = 1'b0;
        code = 5'($urandom);
        for (int n = 0; n < 150; n++) begin
            bit lsync;
            lsync = 1'($urandom);
            ncode = 5'($urandom);
            send(code, $urandom, !prev_last, lsync, ncode, ($urandom_range(3, 0) == 0) ? 2 : 0);
            prev_last = lsync;
            code = lsync ? ncode : 5'($urandom);
            if (!lsync && $urandom_range(1, 0) == 1) idle(int'($urandom_range(3, 1)));
        end
        idle(3);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule